// File: doc/BRIEF.md
# Register-Programmed Watchdog Timer

A supervisory down-counter that firmware must restart periodically. A divider turns pulses from a low-rate oscillator (nominally 32.768 kHz, one enable pulse per oscillator period on the system clock) into a slow tick (nominally 32 Hz). Each slow tick moves the countdown one step toward zero, and counting only happens while the oscillator-run input is high. When the count reaches zero, a sticky timeout flag is raised. That flag is also driven out as a level interrupt whenever the interrupt-enable input is high.

The host controls the block through one 8-bit control register and reads the flag through an 8-bit flags register. Bit 7 of a control write is a restart strobe. Bit 6 is an active-low write enable that guards the 6-bit timeout field in bits 5:0, so firmware can restart the count without disturbing the programmed timeout. A timeout of zero turns the watchdog off. Reading the flags register clears the flag.

Top module: `wdog_timer`

## Requirements
- R1: After synchronous reset the control readback is {0, 1, INIT_TMO} (strobe reads 0, write-protect bit 1, timeout = INIT_TMO), the countdown is loaded with INIT_TMO, and the flag and `irq_o` are 0.
- R2: One slow tick is produced for every DIV_RATIO oscillator pulses seen while `osc_run_i` is high. Pulses are ignored while `osc_run_i` is low, and the divider position is kept.
- R3: Each slow tick lowers the count by one. The slow tick that takes the count from 1 to 0 sets the flag (bit 7 of `flag_rdata_o`) at that clock edge.
- R4: A control write with bit 7 = 1 reloads the count from the timeout field, or from the new field value if the same write changes it. If this happens before zero is reached, no flag appears. A strobe wins over a coincident slow tick, and bit 7 always reads back as 0.
- R5: A control write with bit 6 = 0 replaces the timeout field with bits 5:0. A write with bit 6 = 1 leaves the field unchanged but still acts on its strobe. Bit 6 is stored from every write and read back in bit 6.
- R6: While the timeout field is 0 the count does not move and the flag is never set.
- R7: The flag stays set until a cycle with `flag_rd_i` high, and it clears at the following edge. If a flag-setting tick arrives in the read cycle, the flag stays set.
- R8: After reaching zero the count stays at zero, so the flag is set once per timeout event. It is not set again until a strobe reloads the count.
- R9: `irq_o` is high exactly when the flag is set and `irq_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick_i | input | 1 | One-cycle pulse per oscillator period |
| osc_run_i | input | 1 | Oscillator running; counting enabled |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control write data: [7] restart, [6] write-protect, [5:0] timeout |
| ctl_rdata_o | output | 8 | Control readback {0, write-protect, timeout} |
| flag_rd_i | input | 1 | Flags register read; clears the flag at the next edge |
| flag_rdata_o | output | 8 | Flags register: [7] timeout flag, others 0 |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a flags read that falls in the same cycle as the tick that sets the flag, with the flag already set from an earlier timeout. The bench gets there directly: it programs a timeout of one, restarts the count, and raises the read on the exact cycle it drives the final oscillator pulse of the divider period. Long random runs with mixed writes, reads and oscillator gating then cover strobe/tick collisions and reloads of a zero timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int TMO_W      = 6;
    localparam int REG_W      = 8;
    localparam int STROBE_BIT = 7;
    localparam int WPROT_BIT  = 6;
    localparam int FLAG_BIT   = 7;

    typedef struct packed {
        logic             strobe;
        logic             wprot_n;
        logic [TMO_W-1:0] tmo;
    } wdt_ctl_t;

    function automatic wdt_ctl_t decode_ctl(input logic [REG_W-1:0] d);
        wdt_ctl_t c;
        c.strobe  = d[STROBE_BIT];
        c.wprot_n = d[WPROT_BIT];
        c.tmo     = d[TMO_W-1:0];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_flag(input logic f);
        logic [REG_W-1:0] r;
        r = '0;
        r[FLAG_BIT] = f;
        return r;
    endfunction
endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
    parameter int DIV_RATIO = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick_i,
    input  logic osc_run_i,
    output logic slow_tick_o
);
    localparam int CW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

    logic [CW-1:0] div_cnt;
    logic          adv;

    assign adv         = osc_tick_i && osc_run_i;
    assign slow_tick_o = adv && (div_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
        end else if (adv) begin
            div_cnt <= (div_cnt == LAST) ? '0 : div_cnt + 1'b1;
        end
    end

    p_div_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !osc_run_i |=> $stable(div_cnt));
    p_div_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        slow_tick_o |=> (div_cnt == '0));
endmodule

// File: rtl/wdt_ctl_reg.sv
module wdt_ctl_reg
    import wdt_pkg::*;
#(
    parameter logic [TMO_W-1:0] INIT_TMO = 6'd10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [TMO_W-1:0] tmo_o,
    output logic [TMO_W-1:0] load_val_o,
    output logic             strobe_o,
    output logic [REG_W-1:0] rdata_o
);
    wdt_ctl_t         wc;
    logic             wprot_n;
    logic [TMO_W-1:0] tmo_q;
    logic             upd;

    assign wc         = decode_ctl(wdata_i);
    assign upd        = wr_i && !wc.wprot_n;
    assign load_val_o = upd ? wc.tmo : tmo_q;
    assign strobe_o   = wr_i && wc.strobe;
    assign tmo_o      = tmo_q;
    assign rdata_o    = {1'b0, wprot_n, tmo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            wprot_n <= 1'b1;
            tmo_q   <= INIT_TMO;
        end else begin
            if (wr_i) wprot_n <= wc.wprot_n;
            if (upd)  tmo_q   <= wc.tmo;
        end
    end

    p_wprot_keeps_tmo_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wdata_i[WPROT_BIT]) |=> $stable(tmo_q));
    p_strobe_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rdata_o[STROBE_BIT] == 1'b0);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter logic [TMO_W-1:0] INIT_TMO = 6'd10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slow_tick_i,
    input  logic             strobe_i,
    input  logic [TMO_W-1:0] tmo_i,
    input  logic [TMO_W-1:0] load_val_i,
    input  logic             flag_rd_i,
    output logic             flag_o
);
    logic [TMO_W-1:0] cnt;
    logic             enabled;
    logic             step;
    logic             hit_zero;

    assign enabled  = (tmo_i != '0);
    assign step     = slow_tick_i && enabled && !strobe_i && (cnt != '0);
    assign hit_zero = step && (cnt == TMO_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= INIT_TMO;
            flag_o <= 1'b0;
        end else begin
            if (strobe_i)  cnt <= load_val_i;
            else if (step) cnt <= cnt - 1'b1;

            if (hit_zero)       flag_o <= 1'b1;
            else if (flag_rd_i) flag_o <= 1'b0;
        end
    end

    p_dec_by_one_r3: assert property (@(posedge clk) disable iff (rst)
        (slow_tick_i && !strobe_i && enabled && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    p_flag_on_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (slow_tick_i && !strobe_i && enabled && cnt == TMO_W'(1)) |=> flag_o);
    p_strobe_reload_r4: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> (cnt == $past(load_val_i)));
    p_off_no_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (!enabled && !flag_o) |=> !flag_o);
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !flag_rd_i) |=> flag_o);
    p_hold_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !strobe_i) |=> (cnt == '0));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdt_pkg::*;
#(
    parameter int               DIV_RATIO = 1024,
    parameter logic [TMO_W-1:0] INIT_TMO  = 6'd10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick_i,
    input  logic             osc_run_i,
    input  logic             ctl_wr_i,
    input  logic [REG_W-1:0] ctl_wdata_i,
    output logic [REG_W-1:0] ctl_rdata_o,
    input  logic             flag_rd_i,
    output logic [REG_W-1:0] flag_rdata_o,
    input  logic             irq_en_i,
    output logic             irq_o
);
    logic             slow_tick;
    logic             strobe;
    logic [TMO_W-1:0] tmo;
    logic [TMO_W-1:0] load_val;
    logic             flag;

    wdt_tick_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk         (clk),
        .rst         (rst),
        .osc_tick_i  (osc_tick_i),
        .osc_run_i   (osc_run_i),
        .slow_tick_o (slow_tick)
    );

    wdt_ctl_reg #(.INIT_TMO(INIT_TMO)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (ctl_wr_i),
        .wdata_i    (ctl_wdata_i),
        .tmo_o      (tmo),
        .load_val_o (load_val),
        .strobe_o   (strobe),
        .rdata_o    (ctl_rdata_o)
    );

    wdt_countdown #(.INIT_TMO(INIT_TMO)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .slow_tick_i (slow_tick),
        .strobe_i    (strobe),
        .tmo_i       (tmo),
        .load_val_i  (load_val),
        .flag_rd_i   (flag_rd_i),
        .flag_o      (flag)
    );

    assign flag_rdata_o = pack_flag(flag);
    assign irq_o        = flag && irq_en_i;

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag_rdata_o[FLAG_BIT]);
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
        !irq_en_i |-> !irq_o);
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
    localparam int         DIV = 4;
    localparam logic [5:0] INIT = 6'd5;

    logic       clk = 1'b0;
    logic       rst;
    logic       osc_tick, osc_run, ctl_wr, flag_rd, irq_en;
    logic [7:0] ctl_wdata;
    logic [7:0] ctl_rdata, flag_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // bench reference state
    int         m_div;
    logic [5:0] m_cnt, m_tmo;
    logic       m_wp, m_flag;

    always #4 clk = ~clk;

    wdog_timer #(.DIV_RATIO(DIV), .INIT_TMO(INIT)) u_dut (
        .clk(clk), .rst(rst), .osc_tick_i(osc_tick), .osc_run_i(osc_run),
        .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
        .flag_rd_i(flag_rd), .flag_rdata_o(flag_rdata),
        .irq_en_i(irq_en), .irq_o(irq)
    );

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
            finish_run();
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_flag();
        return {m_flag, 7'b0};
    endfunction
    function automatic logic exp_irq();
        return m_flag & irq_en;
    endfunction
    function automatic logic [7:0] exp_ctl();
        return {1'b0, m_wp, m_tmo};
    endfunction

    task automatic model_edge();
        logic tick, strobe, upd, set;
        logic [5:0] ntmo;
        if (rst) begin
            m_div = 0; m_cnt = INIT; m_tmo = INIT; m_wp = 1'b1; m_flag = 1'b0;
            return;
        end
        tick   = osc_run && osc_tick && (m_div == DIV - 1);
        strobe = ctl_wr && ctl_wdata[7];
        upd    = ctl_wr && !ctl_wdata[6];
        set    = tick && !strobe && (m_tmo != 0) && (m_cnt == 6'd1);
        ntmo   = upd ? ctl_wdata[5:0] : m_tmo;
        if (osc_run && osc_tick) m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
        if (strobe) m_cnt = ntmo;
        else if (tick && m_tmo != 0 && m_cnt != 0) m_cnt = m_cnt - 1'b1;
        if (set) m_flag = 1'b1;
        else if (flag_rd) m_flag = 1'b0;
        if (ctl_wr) m_wp = ctl_wdata[6];
        m_tmo = ntmo;
    endtask

    // one clock: inputs already driven; update model at edge, compare at negedge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R3 flag", flag_rdata, exp_flag());
        check("R9 irq", {7'b0, irq}, {7'b0, exp_irq()});
        check("R5 ctl", ctl_rdata, exp_ctl());
        osc_tick = 1'b0; ctl_wr = 1'b0; flag_rd = 1'b0; ctl_wdata = 8'h00;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            osc_tick = 1'b1;
            step();
        end
    endtask

    task automatic wr(logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        step();
    endtask

    task automatic rd();
        flag_rd = 1'b1;
        step();
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; osc_tick = 0; osc_run = 1; ctl_wr = 0; flag_rd = 0;
        irq_en = 1'b1; ctl_wdata = 8'h00;
        step(); step();
        rst = 1'b0;
        // R1 reset state
        check("R1 ctl reset", ctl_rdata, 8'h45);
        check("R1 flag reset", flag_rdata, 8'h00);
        check("R1 irq reset", {7'b0, irq}, 8'h00);

        // R3: INIT*DIV pulses to timeout, flag exactly at the last one
        pulses(INIT * DIV - 1);
        check("R3 flag before zero", flag_rdata, 8'h00);
        pulses(1);
        check("R3 flag at zero", flag_rdata, 8'h80);
        check("R9 irq with enable", {7'b0, irq}, 8'h01);
        irq_en = 1'b0;
        step();
        check("R9 irq masked", {7'b0, irq}, 8'h00);
        irq_en = 1'b1;

        // R8: held at zero, sticky flag, no re-flag after read
        pulses(10 * DIV);
        check("R7 flag sticky", flag_rdata, 8'h80);
        rd();
        check("R7 flag cleared by read", flag_rdata, 8'h00);
        pulses(20 * DIV);
        check("R8 no reflag at zero", flag_rdata, 8'h00);

        // R4: strobe with protect set keeps timeout, prevents flag
        wr(8'hC0);
        check("R4 strobe keeps tmo", ctl_rdata, 8'h45);
        for (int k = 0; k < 4; k++) begin
            pulses(3 * DIV);
            wr(8'hC0);
        end
        check("R4 strobe prevents flag", flag_rdata, 8'h00);

        // R5: protected write ignored, unprotected write takes effect
        wr(8'h4A);
        check("R5 protected tmo kept", ctl_rdata, 8'h45);
        wr(8'h03);
        check("R5 tmo updated", ctl_rdata, 8'h03);
        wr(8'h83);
        pulses(3 * DIV - 1);
        check("R5 new tmo not yet", flag_rdata, 8'h00);
        pulses(1);
        check("R5 new tmo timeout", flag_rdata, 8'h80);

        // R2: oscillator stopped, pulses ignored
        rd();
        wr(8'hC0);
        osc_run = 1'b0;
        pulses(40);
        check("R2 stopped osc no flag", flag_rdata, 8'h00);
        osc_run = 1'b1;
        pulses(3 * DIV);
        check("R2 resumed timeout", flag_rdata, 8'h80);

        // R7: read coincident with setting tick, flag already set
        wr(8'h81);           // tmo=1, strobe; divider at 0
        pulses(DIV - 1);
        osc_tick = 1'b1; flag_rd = 1'b1;
        step();
        check("R7 set wins over read", flag_rdata, 8'h80);
        rd();

        // R6: zero timeout disables
        wr(8'h80);
        pulses(30 * DIV);
        check("R6 zero tmo no flag", flag_rdata, 8'h00);
        check("R6 zero tmo no irq", {7'b0, irq}, 8'h00);

        // random phase
        wr(8'h82);
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            osc_tick = ($urandom_range(0, 3) != 0);
            osc_run  = ($urandom_range(0, 9) != 0);
            irq_en   = ($urandom_range(0, 3) != 0);
            if (r < 4) begin
                ctl_wr = 1'b1;
                ctl_wdata = {($urandom_range(0, 1) == 1'b1), ($urandom_range(0, 1) == 1'b1),
                             6'($urandom_range(0, 4))};
            end
            flag_rd = ($urandom_range(0, 29) == 0);
            step();
        end
        finish_run();
    end
endmodule